// File: doc/BRIEF.md
# ATAPI Device Task-File Register Interface

This block is the device side of an ATAPI register file. On one side it faces a host bus with a command-block select, a control-block select, a 3-bit address, single-cycle read and write strobes and a 16-bit data bus. On the other side it faces a local sub-CPU port with an 8-bit register window. It stores the task-file registers, decides whether this drive is the one the host addresses, and sets the busy flag. It raises sticky command and soft-reset interrupts to the sub-CPU and gates the host interrupt pin. It also produces per-bit output enables so that the host data bus and the interrupt pin can be tristated outside the block.

Host accesses are sampled on the rising clock edge while a strobe is high. Read data and output enables are combinational from the current address, strobes and register state. Register updates, interrupt flags and busy take effect after the edge. Data-port traffic is passed through as strobes to an external transfer path, and only once the sub-CPU has enabled transfers.

Host command-block map (select `h_cs_cmd`): 0 data, 1 error (read) / features (write), 2 interrupt reason (read only), 3 sector count, 4 byte count low, 5 byte count high, 6 drive select, 7 status (read) / command (write). Control-block map (select `h_cs_ctl`): 6 alternate status (read) / device control (write), 7 drive address (read). An access is valid only when exactly one select is high and exactly one strobe is high. Sub-CPU map, given as write / read: 0 status / status, 1 error / features, 2 interrupt reason / command, 3 sector count / drive select, 4 byte count low / same, 5 byte count high / same, 6 transfer control / same (bit 0 local drive number, bit 1 transfer enable), 7 acknowledge / flags (bit 0 command flag, bit 1 soft-reset flag).

Top module: `atapi_tfile`

## Requirements
- R1: The drive is selected when bit 4 of the drive-select register equals transfer-control bit 0. Drive-select bits 7:5 always read as 1.
- R2: A host command write while selected stores the opcode, sets BSY (status bit 7) and sets the command flag (sub-CPU flags bit 0), all visible in the next cycle.
- R3: A host command write with any opcode other than 90h while not selected is ignored: BSY, the command flag and the stored command stay unchanged.
- R4: A host command write of 90h is accepted like R2 even when the drive is not selected.
- R5: A device-control write with bit 2 set sets BSY and the soft-reset flag (sub-CPU flags bit 1). Bit 1 of every device-control write is stored as the interrupt-disable bit.
- R6: `h_irq_oe` is high only when interrupt-disable is 0 and the drive is selected. `h_irq` shows the pending host interrupt.
- R7: A `s_set_irq` pulse sets the pending host interrupt. A host status read or command write clears it, and an alternate-status read leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R8: A drive-address read enables bits 6:0 only, with value {1, inverted drive-select bits 3:0, 2'b10 when drive 0 is selected, 2'b01 when drive 1 is selected, 2'b11 when not selected}. Other register reads enable bits 7:0, and data reads enable all 16 bits.
- R9: After reset the status register reads 80h, the drive-select register reads E0h, and every other register, flag and the pending interrupt read 0.
- R10: A sub-CPU status write loads all eight status bits, including BSY. A host event that sets BSY in the same cycle overrides the written BSY value.
- R11: The command and soft-reset flags stay set until the sub-CPU writes a 1 to their bit of the acknowledge register. A new event in the same cycle as the acknowledge keeps the flag set.
- R12: With transfer-control bit 1 set, a host data read returns `dat_rdata` and pulses `dat_rd_stb`, and a host data write pulses `dat_wr_stb` with `dat_wdata` equal to the host data. With the bit clear, a data read returns 0 and neither strobe pulses.
- R13: Features, drive select and command values written by the host are readable by the sub-CPU. Error and interrupt reason written by the sub-CPU are readable by the host. Sector count and byte counts are writable from both sides, and the host write wins when both write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs_cmd | input | 1 | Host command-block select |
| h_cs_ctl | input | 1 | Host control-block select |
| h_addr | input | 3 | Host register address |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data |
| h_oe | output | DW | Per-bit output enable for host read data |
| h_irq | output | 1 | Host interrupt level |
| h_irq_oe | output | 1 | Output enable for the host interrupt pin |
| s_addr | input | 3 | Sub-CPU register address |
| s_wr | input | 1 | Sub-CPU write strobe |
| s_wdata | input | 8 | Sub-CPU write data |
| s_rdata | output | 8 | Sub-CPU read data |
| s_set_irq | input | 1 | Sub-CPU request to assert the host interrupt |
| s_cmdi_irq | output | 1 | Sticky command interrupt to the sub-CPU |
| s_srsti_irq | output | 1 | Sticky soft-reset interrupt to the sub-CPU |
| dat_rdata | input | DW | Data from the external transfer path |
| dat_rd_stb | output | 1 | Host data read accepted |
| dat_wr_stb | output | 1 | Host data write accepted |
| dat_wdata | output | DW | Data to the external transfer path |

## Verification
Three pairs of events can fall in the same clock. A sub-CPU status write that clears BSY can land together with a host command or soft-reset write that sets it. An acknowledge of a flag can land together with a new event that sets it. A `s_set_irq` pulse can land together with a host status read or command write. The bench drives both sides in the same cycle for each pair. A behavioural model applies the stated precedence: host set over sub-CPU clear, set over acknowledge, and set over clear. The model's BSY, flags and interrupt level are compared with the ports on the following cycle.

// File: rtl/atapi_tf_pkg.sv
package atapi_tf_pkg;

    localparam int TF_AW = 3;
    localparam int TF_RW = 8;

    // host command-block addresses
    localparam logic [TF_AW-1:0] HA_DATA  = 3'd0;
    localparam logic [TF_AW-1:0] HA_ERR   = 3'd1;
    localparam logic [TF_AW-1:0] HA_IRSN  = 3'd2;
    localparam logic [TF_AW-1:0] HA_SCNT  = 3'd3;
    localparam logic [TF_AW-1:0] HA_BCL   = 3'd4;
    localparam logic [TF_AW-1:0] HA_BCH   = 3'd5;
    localparam logic [TF_AW-1:0] HA_DSEL  = 3'd6;
    localparam logic [TF_AW-1:0] HA_STAT  = 3'd7;
    // host control-block addresses
    localparam logic [TF_AW-1:0] CA_ALT   = 3'd6;
    localparam logic [TF_AW-1:0] CA_DADDR = 3'd7;
    // sub-CPU addresses
    localparam logic [TF_AW-1:0] SA_STAT  = 3'd0;
    localparam logic [TF_AW-1:0] SA_ERR   = 3'd1;
    localparam logic [TF_AW-1:0] SA_IRSN  = 3'd2;
    localparam logic [TF_AW-1:0] SA_SCNT  = 3'd3;
    localparam logic [TF_AW-1:0] SA_BCL   = 3'd4;
    localparam logic [TF_AW-1:0] SA_BCH   = 3'd5;
    localparam logic [TF_AW-1:0] SA_XCTL  = 3'd6;
    localparam logic [TF_AW-1:0] SA_ACK   = 3'd7;

    localparam logic [TF_RW-1:0] DSEL_ONES = 8'hE0;
    localparam logic [TF_RW-1:0] STAT_RST  = 8'h80;

    typedef enum logic [3:0] {
        RS_NONE, RS_DATA, RS_ERR, RS_IRSN, RS_SCNT,
        RS_BCL, RS_BCH, RS_DSEL, RS_STAT, RS_DADDR
    } rsel_e;

    typedef struct packed {
        logic  data_rd;
        logic  data_wr;
        logic  feat_wr;
        logic  scnt_wr;
        logic  bcl_wr;
        logic  bch_wr;
        logic  dsel_wr;
        logic  cmd_wr;
        logic  stat_rd;
        logic  alt_rd;
        logic  dctl_wr;
        rsel_e rsel;
    } hev_t;

    typedef struct packed {
        logic stat_wr;
        logic err_wr;
        logic irsn_wr;
        logic scnt_wr;
        logic bcl_wr;
        logic bch_wr;
        logic xctl_wr;
        logic ack_wr;
    } sev_t;

    // drive-address read value; bit 7 is never driven
    function automatic logic [TF_RW-1:0] daddr_fmt(input logic [TF_RW-1:0] dsel,
                                                   input logic sel);
        logic [1:0] dn;
        if (!sel)        dn = 2'b11;
        else if (dsel[4]) dn = 2'b01;
        else             dn = 2'b10;
        return {1'b0, 1'b1, ~dsel[3:0], dn};
    endfunction

    function automatic sev_t sub_decode(input logic wr, input logic [TF_AW-1:0] a);
        sev_t s;
        s = '0;
        if (wr) begin
            case (a)
                SA_STAT: s.stat_wr = 1'b1;
                SA_ERR:  s.err_wr  = 1'b1;
                SA_IRSN: s.irsn_wr = 1'b1;
                SA_SCNT: s.scnt_wr = 1'b1;
                SA_BCL:  s.bcl_wr  = 1'b1;
                SA_BCH:  s.bch_wr  = 1'b1;
                SA_XCTL: s.xctl_wr = 1'b1;
                default: s.ack_wr  = 1'b1;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/tf_host_decode.sv
module tf_host_decode
    import atapi_tf_pkg::*;
(
    input  logic             cs_cmd,
    input  logic             cs_ctl,
    input  logic [TF_AW-1:0] addr,
    input  logic             rd,
    input  logic             wr,
    input  logic             xfer_en,
    output hev_t             ev
);

    logic one_cs;
    logic rd_ok;
    logic wr_ok;

    assign one_cs = cs_cmd ^ cs_ctl;
    assign rd_ok  = one_cs & rd & ~wr;
    assign wr_ok  = one_cs & wr & ~rd;

    always_comb begin
        ev      = '0;
        ev.rsel = RS_NONE;
        if (cs_cmd) begin
            if (rd_ok) begin
                case (addr)
                    HA_DATA: begin ev.rsel = RS_DATA; ev.data_rd = xfer_en; end
                    HA_ERR:  ev.rsel = RS_ERR;
                    HA_IRSN: ev.rsel = RS_IRSN;
                    HA_SCNT: ev.rsel = RS_SCNT;
                    HA_BCL:  ev.rsel = RS_BCL;
                    HA_BCH:  ev.rsel = RS_BCH;
                    HA_DSEL: ev.rsel = RS_DSEL;
                    default: begin ev.rsel = RS_STAT; ev.stat_rd = 1'b1; end
                endcase
            end
            if (wr_ok) begin
                case (addr)
                    HA_DATA: ev.data_wr = xfer_en;
                    HA_ERR:  ev.feat_wr = 1'b1;
                    HA_SCNT: ev.scnt_wr = 1'b1;
                    HA_BCL:  ev.bcl_wr  = 1'b1;
                    HA_BCH:  ev.bch_wr  = 1'b1;
                    HA_DSEL: ev.dsel_wr = 1'b1;
                    HA_STAT: ev.cmd_wr  = 1'b1;
                    default: ;
                endcase
            end
        end else if (cs_ctl) begin
            if (rd_ok) begin
                if (addr == CA_ALT) begin
                    ev.rsel   = RS_STAT;
                    ev.alt_rd = 1'b1;
                end else if (addr == CA_DADDR) begin
                    ev.rsel = RS_DADDR;
                end
            end
            if (wr_ok && addr == CA_ALT) ev.dctl_wr = 1'b1;
        end
    end

endmodule

// File: rtl/tf_regs.sv
module tf_regs
    import atapi_tf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  hev_t             ev,
    input  logic [TF_RW-1:0] h_wdata,
    input  logic             cmd_accept,
    input  sev_t             sev,
    input  logic [TF_RW-1:0] s_wdata,
    output logic [TF_RW-1:0] feat,
    output logic [TF_RW-1:0] err,
    output logic [TF_RW-1:0] irsn,
    output logic [TF_RW-1:0] scnt,
    output logic [TF_RW-1:0] bcl,
    output logic [TF_RW-1:0] bch,
    output logic [TF_RW-1:0] dsel,
    output logic [TF_RW-1:0] cmd,
    output logic [TF_RW-2:0] stat_lo,
    output logic             nien,
    output logic             rdrv,
    output logic             xen,
    output logic             sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            feat    <= '0;
            err     <= '0;
            irsn    <= '0;
            scnt    <= '0;
            bcl     <= '0;
            bch     <= '0;
            dsel    <= DSEL_ONES;
            cmd     <= '0;
            stat_lo <= '0;
            nien    <= 1'b0;
            rdrv    <= 1'b0;
            xen     <= 1'b0;
        end else begin
            if (ev.feat_wr)    feat    <= h_wdata;
            if (ev.dsel_wr)    dsel    <= h_wdata | DSEL_ONES;
            if (cmd_accept)    cmd     <= h_wdata;
            if (ev.dctl_wr)    nien    <= h_wdata[1];
            if (sev.err_wr)    err     <= s_wdata;
            if (sev.irsn_wr)   irsn    <= s_wdata;
            if (sev.stat_wr)   stat_lo <= s_wdata[TF_RW-2:0];
            if (sev.xctl_wr) begin
                rdrv <= s_wdata[0];
                xen  <= s_wdata[1];
            end
            // shared registers: host side takes precedence
            if (ev.scnt_wr)       scnt <= h_wdata;
            else if (sev.scnt_wr) scnt <= s_wdata;
            if (ev.bcl_wr)        bcl  <= h_wdata;
            else if (sev.bcl_wr)  bcl  <= s_wdata;
            if (ev.bch_wr)        bch  <= h_wdata;
            else if (sev.bch_wr)  bch  <= s_wdata;
        end
    end

    assign sel = (dsel[4] == rdrv);

    p_host_wins_r13: assert property (@(posedge clk) disable iff (rst)
        (ev.scnt_wr && sev.scnt_wr) |=> (scnt == $past(h_wdata)))
        else $error("host write lost on shared sector count");

    p_cmd_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (ev.cmd_wr && !cmd_accept) |=> $stable(cmd))
        else $error("rejected command changed command register");

endmodule

// File: rtl/tf_irq_ctl.sv
module tf_irq_ctl
    import atapi_tf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  hev_t             ev,
    input  logic [TF_RW-1:0] h_wdata,
    input  logic             cmd_accept,
    input  sev_t             sev,
    input  logic [TF_RW-1:0] s_wdata,
    input  logic             set_irq,
    output logic             bsy,
    output logic             cmdi,
    output logic             srsti,
    output logic             pend
);

    logic srst_evt;
    logic ack_cmdi;
    logic ack_srsti;

    assign srst_evt  = ev.dctl_wr & h_wdata[2];
    assign ack_cmdi  = sev.ack_wr & s_wdata[0];
    assign ack_srsti = sev.ack_wr & s_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bsy   <= 1'b1;
            cmdi  <= 1'b0;
            srsti <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (cmd_accept || srst_evt) bsy <= 1'b1;
            else if (sev.stat_wr)       bsy <= s_wdata[TF_RW-1];

            if (cmd_accept)    cmdi <= 1'b1;
            else if (ack_cmdi) cmdi <= 1'b0;

            if (srst_evt)       srsti <= 1'b1;
            else if (ack_srsti) srsti <= 1'b0;

            if (set_irq)                      pend <= 1'b1;
            else if (ev.stat_rd || ev.cmd_wr) pend <= 1'b0;
        end
    end

    p_bsy_set_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept || srst_evt) |=> bsy)
        else $error("busy not set by host event");

    p_srst_flag_r5: assert property (@(posedge clk) disable iff (rst)
        srst_evt |=> srsti)
        else $error("soft-reset flag not raised");

    p_cmdi_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (cmdi && !ack_cmdi) |=> cmdi)
        else $error("command flag dropped without acknowledge");

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && ev.stat_rd && !set_irq) |=> !pend)
        else $error("status read left interrupt pending");

    p_alt_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && ev.alt_rd) |=> pend)
        else $error("alternate status read cleared interrupt");

endmodule

// File: rtl/atapi_tfile.sv
module atapi_tfile
    import atapi_tf_pkg::*;
#(
    parameter int               DW      = 16,
    parameter logic [TF_RW-1:0] DIAG_OP = 8'h90
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_cs_cmd,
    input  logic             h_cs_ctl,
    input  logic [TF_AW-1:0] h_addr,
    input  logic             h_rd,
    input  logic             h_wr,
    input  logic [DW-1:0]    h_wdata,
    output logic [DW-1:0]    h_rdata,
    output logic [DW-1:0]    h_oe,
    output logic             h_irq,
    output logic             h_irq_oe,
    input  logic [TF_AW-1:0] s_addr,
    input  logic             s_wr,
    input  logic [TF_RW-1:0] s_wdata,
    output logic [TF_RW-1:0] s_rdata,
    input  logic             s_set_irq,
    output logic             s_cmdi_irq,
    output logic             s_srsti_irq,
    input  logic [DW-1:0]    dat_rdata,
    output logic             dat_rd_stb,
    output logic             dat_wr_stb,
    output logic [DW-1:0]    dat_wdata
);

    localparam int PADW = DW - TF_RW;
    localparam logic [DW-1:0] OE_REG   = {{PADW{1'b0}}, 8'hFF};
    localparam logic [DW-1:0] OE_DADDR = {{PADW{1'b0}}, 8'h7F};

    hev_t             ev;
    sev_t             sev;
    logic [TF_RW-1:0] hw8;
    logic             cmd_accept;
    logic [TF_RW-1:0] feat, err, irsn, scnt, bcl, bch, dsel, cmd;
    logic [TF_RW-2:0] stat_lo;
    logic             nien, rdrv, xen, sel;
    logic             bsy, cmdi, srsti, pend;
    logic [TF_RW-1:0] stat;
    logic [TF_RW-1:0] rreg;

    assign hw8        = h_wdata[TF_RW-1:0];
    assign sev        = sub_decode(s_wr, s_addr);
    assign cmd_accept = ev.cmd_wr & (sel | (hw8 == DIAG_OP));
    assign stat       = {bsy, stat_lo};

    tf_host_decode u_dec (
        .cs_cmd  (h_cs_cmd),
        .cs_ctl  (h_cs_ctl),
        .addr    (h_addr),
        .rd      (h_rd),
        .wr      (h_wr),
        .xfer_en (xen),
        .ev      (ev)
    );

    tf_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .h_wdata    (hw8),
        .cmd_accept (cmd_accept),
        .sev        (sev),
        .s_wdata    (s_wdata),
        .feat       (feat),
        .err        (err),
        .irsn       (irsn),
        .scnt       (scnt),
        .bcl        (bcl),
        .bch        (bch),
        .dsel       (dsel),
        .cmd        (cmd),
        .stat_lo    (stat_lo),
        .nien       (nien),
        .rdrv       (rdrv),
        .xen        (xen),
        .sel        (sel)
    );

    tf_irq_ctl u_irq (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .h_wdata    (hw8),
        .cmd_accept (cmd_accept),
        .sev        (sev),
        .s_wdata    (s_wdata),
        .set_irq    (s_set_irq),
        .bsy        (bsy),
        .cmdi       (cmdi),
        .srsti      (srsti),
        .pend       (pend)
    );

    // host read path
    always_comb begin
        rreg = '0;
        case (ev.rsel)
            RS_ERR:   rreg = err;
            RS_IRSN:  rreg = irsn;
            RS_SCNT:  rreg = scnt;
            RS_BCL:   rreg = bcl;
            RS_BCH:   rreg = bch;
            RS_DSEL:  rreg = dsel;
            RS_STAT:  rreg = stat;
            RS_DADDR: rreg = daddr_fmt(dsel, sel);
            default:  rreg = '0;
        endcase
    end

    always_comb begin
        if (ev.rsel == RS_DATA) begin
            h_rdata = xen ? dat_rdata : '0;
            h_oe    = '1;
        end else begin
            h_rdata = {{PADW{1'b0}}, rreg};
            case (ev.rsel)
                RS_NONE:  h_oe = '0;
                RS_DADDR: h_oe = OE_DADDR;
                default:  h_oe = OE_REG;
            endcase
        end
    end

    // sub-CPU read path
    always_comb begin
        case (s_addr)
            SA_STAT: s_rdata = stat;
            SA_ERR:  s_rdata = feat;
            SA_IRSN: s_rdata = cmd;
            SA_SCNT: s_rdata = dsel;
            SA_BCL:  s_rdata = bcl;
            SA_BCH:  s_rdata = bch;
            SA_XCTL: s_rdata = {6'b0, xen, rdrv};
            default: s_rdata = {6'b0, srsti, cmdi};
        endcase
    end

    assign h_irq       = pend;
    assign h_irq_oe    = ~nien & sel;
    assign s_cmdi_irq  = cmdi;
    assign s_srsti_irq = srsti;
    assign dat_rd_stb  = ev.data_rd;
    assign dat_wr_stb  = ev.data_wr;
    assign dat_wdata   = h_wdata;

    p_irq_hiz_r6: assert property (@(posedge clk) disable iff (rst)
        nien |-> !h_irq_oe)
        else $error("interrupt pin enabled while disabled");

    p_unsel_no_pin_r1: assert property (@(posedge clk) disable iff (rst)
        (dsel[4] != rdrv) |-> !h_irq_oe)
        else $error("interrupt pin enabled while not selected");

endmodule

// File: tb/sim_atapi_tfile.sv
module sim_atapi_tfile;

    localparam int PERIOD = 10;
    localparam int DW     = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          h_cs_cmd = 0, h_cs_ctl = 0, h_rd = 0, h_wr = 0;
    logic [2:0]    h_addr = 0;
    logic [DW-1:0] h_wdata = 0;
    logic [DW-1:0] h_rdata, h_oe;
    logic          h_irq, h_irq_oe;
    logic [2:0]    s_addr = 0;
    logic          s_wr = 0, s_set_irq = 0;
    logic [7:0]    s_wdata = 0;
    logic [7:0]    s_rdata;
    logic          s_cmdi_irq, s_srsti_irq;
    logic [DW-1:0] dat_rdata = 16'hBEEF;
    logic          dat_rd_stb, dat_wr_stb;
    logic [DW-1:0] dat_wdata;

    always #(PERIOD/2) clk = ~clk;

    atapi_tfile u0 (
        .clk(clk), .rst(rst),
        .h_cs_cmd(h_cs_cmd), .h_cs_ctl(h_cs_ctl), .h_addr(h_addr),
        .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_oe(h_oe), .h_irq(h_irq), .h_irq_oe(h_irq_oe),
        .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .s_set_irq(s_set_irq), .s_cmdi_irq(s_cmdi_irq), .s_srsti_irq(s_srsti_irq),
        .dat_rdata(dat_rdata), .dat_rd_stb(dat_rd_stb), .dat_wr_stb(dat_wr_stb),
        .dat_wdata(dat_wdata)
    );

    int total = 0;
    int bad   = 0;
    string cur_req = "R9";

    // behavioural reference state
    int m_feat, m_err, m_irsn, m_scnt, m_bcl, m_bch, m_dsel, m_cmd, m_stat;
    int m_bsy, m_nien, m_rdrv, m_xen, m_cmdi, m_srsti, m_pend;

    task automatic model_reset();
        m_feat = 0; m_err = 0; m_irsn = 0; m_scnt = 0; m_bcl = 0; m_bch = 0;
        m_dsel = 'hE0; m_cmd = 0; m_stat = 0; m_bsy = 1; m_nien = 0;
        m_rdrv = 0; m_xen = 0; m_cmdi = 0; m_srsti = 0; m_pend = 0;
    endtask

    task automatic cmp(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // one clock: compare outputs with the model, then advance the model
    task automatic tick(input bit check);
        int sel, hv, rdv, wrv, exp_d, exp_oe, sr, a, w, acc;
        @(negedge clk);
        #1;
        sel = ((m_dsel >> 4) & 1) == m_rdrv;
        hv  = (h_cs_cmd != h_cs_ctl);
        rdv = hv && h_rd && !h_wr;
        wrv = hv && h_wr && !h_rd;
        a   = h_addr;
        w   = h_wdata & 'hFF;
        exp_d = 0; exp_oe = 0;
        if (rdv && h_cs_cmd) begin
            exp_oe = 'hFF;
            case (a)
                0: begin exp_oe = 'hFFFF; exp_d = m_xen ? dat_rdata : 0; end
                1: exp_d = m_err;
                2: exp_d = m_irsn;
                3: exp_d = m_scnt;
                4: exp_d = m_bcl;
                5: exp_d = m_bch;
                6: exp_d = m_dsel;
                default: exp_d = m_bsy * 128 + m_stat;
            endcase
        end else if (rdv && h_cs_ctl && a == 6) begin
            exp_oe = 'hFF; exp_d = m_bsy * 128 + m_stat;
        end else if (rdv && h_cs_ctl && a == 7) begin
            exp_oe = 'h7F;
            exp_d = 'h40 | (((~m_dsel) & 'hF) << 2) |
                    (!sel ? 3 : (((m_dsel >> 4) & 1) ? 1 : 2));
        end
        case (s_addr)
            0: sr = m_bsy * 128 + m_stat;
            1: sr = m_feat;
            2: sr = m_cmd;
            3: sr = m_dsel;
            4: sr = m_bcl;
            5: sr = m_bch;
            6: sr = m_xen * 2 + m_rdrv;
            default: sr = m_srsti * 2 + m_cmdi;
        endcase
        if (check) begin
            cmp("h_oe", h_oe, exp_oe);
            cmp("h_rdata", h_rdata & exp_oe, exp_d);
            cmp("h_irq", h_irq, m_pend);
            cmp("h_irq_oe", h_irq_oe, (m_nien == 0) && sel);
            cmp("s_rdata", s_rdata, sr);
            cmp("s_cmdi_irq", s_cmdi_irq, m_cmdi);
            cmp("s_srsti_irq", s_srsti_irq, m_srsti);
            cmp("dat_rd_stb", dat_rd_stb, rdv && h_cs_cmd && a == 0 && m_xen);
            cmp("dat_wr_stb", dat_wr_stb, wrv && h_cs_cmd && a == 0 && m_xen);
            if (wrv && h_cs_cmd && a == 0 && m_xen) cmp("dat_wdata", dat_wdata, h_wdata);
        end
        // next state
        if (rst) begin
            model_reset();
        end else begin
            acc = wrv && h_cs_cmd && a == 7 && (sel || w == 'h90);
            if (s_wr && s_addr == 0) begin m_stat = s_wdata & 'h7F; m_bsy = s_wdata[7]; end
            if (s_wr && s_addr == 1) m_err  = s_wdata;
            if (s_wr && s_addr == 2) m_irsn = s_wdata;
            if (s_wr && s_addr == 3) m_scnt = s_wdata;
            if (s_wr && s_addr == 4) m_bcl  = s_wdata;
            if (s_wr && s_addr == 5) m_bch  = s_wdata;
            if (s_wr && s_addr == 6) begin m_rdrv = s_wdata[0]; m_xen = s_wdata[1]; end
            if (s_wr && s_addr == 7) begin
                if (s_wdata[0]) m_cmdi = 0;
                if (s_wdata[1]) m_srsti = 0;
            end
            if (rdv && h_cs_cmd && a == 7) m_pend = 0;
            if (wrv && h_cs_cmd) begin
                case (a)
                    1: m_feat = w;
                    3: m_scnt = w;
                    4: m_bcl  = w;
                    5: m_bch  = w;
                    6: m_dsel = w | 'hE0;
                    7: m_pend = 0;
                    default: ;
                endcase
            end
            if (acc) begin m_cmd = w; m_bsy = 1; m_cmdi = 1; end
            if (wrv && h_cs_ctl && a == 6) begin
                m_nien = (w >> 1) & 1;
                if (w[2]) begin m_bsy = 1; m_srsti = 1; end
            end
            if (s_set_irq) m_pend = 1;
        end
        @(posedge clk);
        #1;
        h_cs_cmd = 0; h_cs_ctl = 0; h_rd = 0; h_wr = 0;
        s_wr = 0; s_set_irq = 0;
    endtask

    task automatic hwr(input bit ctl, input int a, input int d);
        h_cs_cmd = !ctl; h_cs_ctl = ctl; h_addr = a[2:0]; h_wdata = d[15:0]; h_wr = 1;
    endtask
    task automatic hrd(input bit ctl, input int a);
        h_cs_cmd = !ctl; h_cs_ctl = ctl; h_addr = a[2:0]; h_rd = 1;
    endtask
    task automatic swr(input int a, input int d);
        s_addr = a[2:0]; s_wdata = d[7:0]; s_wr = 1;
    endtask

    bit done = 0;

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1;
        tick(0); tick(0);
        rst = 0;
        // R9: reset values
        cur_req = "R9";
        for (int i = 0; i < 8; i++) begin s_addr = i[2:0]; tick(1); end
        hrd(0, 6); tick(1);
        hrd(0, 7); tick(1);
        // R10: sub-CPU status load
        cur_req = "R10";
        swr(0, 'h58); tick(1);
        s_addr = 0; hrd(0, 7); tick(1);
        swr(0, 'h00); tick(1);
        // R2: selected command
        cur_req = "R2";
        hwr(0, 7, 'hA0); tick(1);
        s_addr = 2; tick(1);
        s_addr = 0; tick(1);
        // R11: acknowledge
        cur_req = "R11";
        swr(7, 1); tick(1);
        s_addr = 7; tick(1);
        swr(0, 0); tick(1);
        // R1 / R3: deselect and ignored command
        cur_req = "R1";
        hwr(0, 6, 'h1A); tick(1);
        hrd(0, 6); tick(1);
        cur_req = "R3";
        hwr(0, 7, 'h55); tick(1);
        s_addr = 2; tick(1);
        s_addr = 7; tick(1);
        s_addr = 0; tick(1);
        cur_req = "R8";
        hrd(1, 7); tick(1);
        // R4: diagnostic opcode while unselected
        cur_req = "R4";
        hwr(0, 7, 'h90); tick(1);
        s_addr = 2; tick(1);
        s_addr = 7; tick(1);
        swr(7, 1); tick(1);
        swr(0, 0); tick(1);
        // R1: local drive number follows
        cur_req = "R1";
        swr(6, 1); tick(1);
        cur_req = "R8";
        hrd(1, 7); tick(1);
        hwr(0, 6, 'h05); tick(1);
        hrd(1, 7); tick(1);
        swr(6, 0); tick(1);
        hrd(1, 7); tick(1);
        // R5: soft reset and interrupt disable
        cur_req = "R5";
        hwr(1, 6, 'h04); tick(1);
        s_addr = 7; tick(1);
        s_addr = 0; tick(1);
        hwr(1, 6, 'h02); tick(1);
        cur_req = "R6";
        tick(1);
        hwr(1, 6, 'h00); tick(1);
        swr(7, 2); tick(1);
        swr(0, 0); tick(1);
        // R7: pending interrupt handling
        cur_req = "R7";
        s_set_irq = 1; tick(1);
        hrd(1, 6); tick(1);
        hrd(1, 6); tick(1);
        hrd(0, 7); tick(1);
        tick(1);
        s_set_irq = 1; tick(1);
        hwr(0, 2, 'h33); tick(1);
        hwr(0, 7, 'hA1); tick(1);
        s_set_irq = 1; hrd(0, 7); tick(1);
        tick(1);
        s_set_irq = 1; hwr(0, 7, 'hA2); tick(1);
        hrd(0, 7); tick(1);
        // R6: unselected pin released
        cur_req = "R6";
        swr(6, 1); tick(1);
        tick(1);
        swr(6, 0); tick(1);
        // R10 / R11: same-cycle collisions
        cur_req = "R10";
        swr(7, 3); tick(1);
        swr(0, 'h00); hwr(0, 7, 'hA3); tick(1);
        s_addr = 0; tick(1);
        swr(0, 'h01); hwr(1, 6, 'h04); tick(1);
        s_addr = 0; tick(1);
        cur_req = "R11";
        swr(7, 1); hwr(0, 7, 'hA4); tick(1);
        s_addr = 7; tick(1);
        swr(7, 2); hwr(1, 6, 'h04); tick(1);
        s_addr = 7; tick(1);
        swr(7, 3); tick(1);
        s_addr = 7; tick(1);
        // R12: data path gating
        cur_req = "R12";
        hrd(0, 0); tick(1);
        hwr(0, 0, 'h1234); tick(1);
        swr(6, 2); tick(1);
        dat_rdata = 16'hC3A5; hrd(0, 0); tick(1);
        hwr(0, 0, 'h5AF0); tick(1);
        dat_rdata = 16'h0F0F; hrd(0, 0); tick(1);
        swr(6, 0); tick(1);
        hrd(0, 0); tick(1);
        // R13: register exchange
        cur_req = "R13";
        hwr(0, 1, 'h3C); tick(1);
        s_addr = 1; tick(1);
        swr(1, 'h81); tick(1);
        hrd(0, 1); tick(1);
        swr(2, 'h03); tick(1);
        hrd(0, 2); tick(1);
        swr(3, 'h11); hwr(0, 3, 'h22); tick(1);
        hrd(0, 3); tick(1);
        swr(4, 'h44); tick(1);
        hrd(0, 4); tick(1);
        swr(5, 'h66); hwr(0, 5, 'h77); tick(1);
        hrd(0, 5); tick(1);
        s_addr = 5; tick(1);
        // invalid accesses: both selects, both strobes
        h_cs_cmd = 1; h_cs_ctl = 1; h_addr = 3; h_wr = 1; h_wdata = 'h99; tick(1);
        hrd(0, 3); h_wr = 1; tick(1);
        hrd(0, 3); tick(1);
        // R9: reset mid-run
        cur_req = "R9";
        rst = 1; tick(1);
        rst = 0;
        for (int i = 0; i < 8; i++) begin s_addr = i[2:0]; tick(1); end
        hrd(0, 3); tick(1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule